// File: doc/BRIEF.md
# Serial word transmitter with forwarded line clock

This block takes a parallel data word and shifts it out one bit at a time on a single data wire, with a clock on a second wire beside it. The word is offered on a valid/ready input. When the block is idle it raises `in_ready`, and the word is taken on any cycle where `in_valid` and `in_ready` are both high. Back-pressure is simple: `in_ready` stays low from that handshake until the last bit has gone out. While it is low, a source may hold `in_valid` and its word. The held word is taken in the first cycle the block is idle again.

On acceptance the block latches the word, clears its bit index to zero and starts a forwarded line clock. The line clock has a half period of `HALF_CYC` system cycles. The bit index advances on each falling edge of the line clock, and the data wire always carries the true value of the indexed bit. A receiver therefore samples on the rising edge. The frame has no start or stop bits. The two ends stay in step because the receiver counts line-clock edges from an index it also clears before each word.

After the falling edge that ends the last bit, `done` goes high and stays high until the next word is accepted. The data wire then idles high and the line clock idles low.

Top module: `txs_top`

## Requirements
- R1: `in_ready` is high exactly when no word is being sent. A word is accepted only on a cycle where `in_valid` and `in_ready` are both high. `in_valid` asserted while `in_ready` is low is held off until the block is idle.
- R2: Acceptance clears the bit index to 0. Bits go out least significant first: bit 0 first, then indices 1, 2 and so on up to `WORD_W-1`.
- R3: While a word is being sent, `ser_data` equals the true, non-inverted value of the latched word bit selected by the index. It is stable across every rising edge of `ser_clk`.
- R4: `ser_clk` is low in the cycle after acceptance. While sending, it toggles every `HALF_CYC` system cycles, so rising edges within a word are `2*HALF_CYC` cycles apart. It is low whenever the block is idle.
- R5: The bit index changes only on a falling edge of `ser_clk`. Exactly `WORD_W` rising edges appear per word.
- R6: After the falling edge that ends bit `WORD_W-1`, `done` is 1, `ser_data` is 1, `ser_clk` is 0 and `in_ready` is 1.
- R7: `done` is 0 after reset and returns to 0 in the cycle after the next acceptance.
- R8: After reset, `in_ready` is 1, `ser_data` is 1, `ser_clk` is 0 and `done` is 0.
- R9: Changes on `in_word` after acceptance have no effect on the bits sent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Word offered |
| in_ready | output | 1 | Block idle, word will be taken |
| in_word | input | WORD_W | Parallel word to send |
| ser_data | output | 1 | Serial data wire, idles high |
| ser_clk | output | 1 | Forwarded line clock, idles low |
| done | output | 1 | Last word fully sent |

## Verification
The assertions assume that `in_valid` and `in_word` change only between clock edges, and that a source never withdraws the handshake in the cycle it completes. They also assume that reset is held for at least one edge before any traffic. The bench drives every input on the falling system edge and samples on the same edge. It keeps `in_valid` high until it has seen `in_ready`. Words go out back to back while a second word is already waiting. The bench also overwrites `in_word` during a send, so that every check relies on the handshake rule alone.

// File: rtl/txs_pkg.sv
package txs_pkg;
  typedef enum logic {TX_IDLE = 1'b0, TX_SEND = 1'b1} txs_state_e;
endpackage

// File: rtl/txs_phase.sv
module txs_phase #(
  parameter int HALF_CYC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic restart,
  output logic lclk,
  output logic fall
);
  localparam int CNT_W = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HALF_CYC - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             lclk_q;

  always_ff @(posedge clk) begin
    if (!rst_n || restart || !run) begin
      cnt_q  <= '0;
      lclk_q <= 1'b0;
    end else if (cnt_q == CNT_LAST) begin
      cnt_q  <= '0;
      lclk_q <= ~lclk_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign lclk = lclk_q;
  assign fall = run && !restart && lclk_q && (cnt_q == CNT_LAST);

  // R4: the line clock only moves when the counter wraps
  assert_half_period_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !restart && cnt_q != CNT_LAST) |=> $stable(lclk_q));
endmodule

// File: rtl/txs_index.sv
module txs_index #(
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             step,
  output logic [IDX_W-1:0] idx,
  output logic             last
);
  logic [IDX_W-1:0] idx_q;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) idx_q <= '0;
    else if (step)     idx_q <= idx_q + 1'b1;
  end

  assign idx  = idx_q;
  assign last = &idx_q;

  // R2: a clear always leaves the index at zero
  assert_clear_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (idx_q == '0));
endmodule

// File: rtl/txs_select.sv
module txs_select #(
  parameter int WORD_W = 16,
  parameter int IDX_W  = 4
) (
  input  logic [WORD_W-1:0] word,
  input  logic [IDX_W-1:0]  idx,
  input  logic              en,
  output logic              bit_o
);
  logic [WORD_W-1:0] onehot;

  for (genvar g = 0; g < WORD_W; g++) begin : g_dec
    assign onehot[g] = (idx == IDX_W'(g));
  end

  assign bit_o = en ? |(onehot & word) : 1'b1;
endmodule

// File: rtl/txs_top.sv
module txs_top #(
  parameter int WORD_W   = 16,
  parameter int HALF_CYC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_word,
  output logic              ser_data,
  output logic              ser_clk,
  output logic              done
);
  import txs_pkg::*;
  localparam int IDX_W = $clog2(WORD_W);

  txs_state_e        state_q;
  logic [WORD_W-1:0] word_q;
  logic              done_q;
  logic              accept, busy, fall, last;
  logic [IDX_W-1:0]  idx;

  assign busy     = (state_q == TX_SEND);
  assign in_ready = !busy;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= TX_IDLE;
      word_q  <= '0;
      done_q  <= 1'b0;
    end else if (accept) begin
      state_q <= TX_SEND;
      word_q  <= in_word;
      done_q  <= 1'b0;
    end else if (fall && last) begin
      state_q <= TX_IDLE;
      done_q  <= 1'b1;
    end
  end

  txs_phase #(.HALF_CYC(HALF_CYC)) u_phase (
    .clk(clk), .rst_n(rst_n), .run(busy), .restart(accept),
    .lclk(ser_clk), .fall(fall));

  txs_index #(.IDX_W(IDX_W)) u_index (
    .clk(clk), .rst_n(rst_n), .clr(accept), .step(fall && !last),
    .idx(idx), .last(last));

  txs_select #(.WORD_W(WORD_W), .IDX_W(IDX_W)) u_select (
    .word(word_q), .idx(idx), .en(busy), .bit_o(ser_data));

  assign done = done_q;

  // R1/R2: an accepted word starts at index 0 with the clock low
  assert_start_clean_R2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (busy && idx == '0 && !ser_clk));
  // R5: index moves only with a falling line clock
  assert_step_on_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && idx != $past(idx)) |-> $fell(ser_clk));
  // R4/R6: idle wires
  assert_idle_lines_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (ser_data && !ser_clk));
  // R7: done only while idle
  assert_done_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> in_ready);
endmodule

// File: tb/txs_top_bench.sv
module txs_top_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WORD_W     = 16;
  localparam int HALF_CYC   = 2;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              in_valid = 1'b0;
  logic [WORD_W-1:0] in_word = '0;
  logic              in_ready, ser_data, ser_clk, done;

  int n_checks = 0;
  int n_fail   = 0;
  int cyc      = 0;
  bit exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  txs_top #(.WORD_W(WORD_W), .HALF_CYC(HALF_CYC)) u_txs_top (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_word(in_word), .ser_data(ser_data), .ser_clk(ser_clk), .done(done));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // monitor: pops one expected bit per rising line-clock edge
  logic prev_clk = 1'b0;
  int   last_rise = 0;
  int   rises = 0;
  always @(negedge clk) begin
    if (rst_n && ser_clk && !prev_clk) begin
      if (exp_q.size() == 0) check(1'b0, "R5 extra rising edge", 1, 0);
      else begin
        bit e;
        e = exp_q.pop_front();
        check(ser_data == e, "R3/R9 serial bit", ser_data, e);
      end
      if (rises % WORD_W != 0)
        check(cyc - last_rise == 2*HALF_CYC, "R4 rise spacing", cyc - last_rise, 2*HALF_CYC);
      last_rise = cyc;
      rises++;
    end
    prev_clk = ser_clk;
  end

  // driver: offer a word, push its bits once the handshake happens
  task automatic send(input logic [WORD_W-1:0] w, input bit scramble, input bit expect_wait);
    @(negedge clk);
    in_word  = w;
    in_valid = 1'b1;
    if (expect_wait) check(in_ready == 1'b0, "R1 ready low while busy", in_ready, 0);
    while (!in_ready) @(negedge clk);
    for (int i = 0; i < WORD_W; i++) exp_q.push_back(w[i]);
    @(negedge clk);
    in_valid = 1'b0;
    check(done == 1'b0, "R7 done cleared on accept", done, 0);
    check(ser_clk == 1'b0, "R4 clock low after accept", ser_clk, 0);
    check(ser_data == w[0], "R2 bit 0 first", ser_data, w[0]);
    if (scramble) in_word = ~w;
  endtask

  task automatic wait_done(input string tag);
    while (!done) @(negedge clk);
    check(ser_data == 1'b1, "R6 data idles high", ser_data, 1);
    check(ser_clk == 1'b0, "R6 clock idles low", ser_clk, 0);
    check(in_ready == 1'b1, "R6 ready after word", in_ready, 1);
    check(exp_q.size() == 0, {"R5 all bits sent ", tag}, exp_q.size(), 0);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(in_ready == 1'b1, "R8 ready", in_ready, 1);
    check(ser_data == 1'b1, "R8 data", ser_data, 1);
    check(ser_clk == 1'b0, "R8 clock", ser_clk, 0);
    check(done == 1'b0, "R8/R7 done", done, 0);
    // R1: no handshake without valid
    repeat (5) @(negedge clk);
    check(ser_clk == 1'b0 && in_ready, "R1 idle without valid", ser_clk, 0);

    send(16'hA5C3, 1'b0, 1'b0); wait_done("w1");
    send(16'h0001, 1'b1, 1'b0); wait_done("R9 scrambled");
    send(16'h8000, 1'b0, 1'b0); wait_done("w3");
    send(16'hFFFF, 1'b0, 1'b0); wait_done("w4");
    // R1 back to back: second word offered while busy
    send(16'h0000, 1'b0, 1'b0);
    send(16'h3C96, 1'b1, 1'b1);
    wait_done("back to back");
    repeat (10) @(negedge clk);
    check(done == 1'b1, "R7 done held", done, 1);
    check(rises == 6*WORD_W, "R5 rise count", rises, 6*WORD_W);

    $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule